// File: doc/BRIEF.md
# Parallel Flash Host Bus Front End

This block models the host-facing side of an asynchronous parallel flash memory inside a synchronous fabric. It samples the active-low chip enable, output enable and write enable pins, the active-low hardware reset pin and a word/byte mode pin on the system clock. It decodes them into exactly one bus operation per cycle: reset, standby, read, write or output disable.

Reads return words from a small internal array whose contents are computed at start-up. The 16-bit data bus is split into a data-in vector, a data-out vector and a per-bit drive enable. In byte mode the top data pin stops being data and becomes the lowest address bit, which chooses the byte of the addressed word that is placed on the low lane.

Write cycles capture an address and a data value. On the clock after the write ends, a one-cycle strobe hands the captured pair to downstream command logic. The array is read-only from this interface, so reads are available straight after reset with no command sequence.

Top module: `pflash_bus_if`

## Requirements
- R1: `bus_op` encodes the sampled pins as 0 = reset, 1 = standby, 2 = read, 3 = write and 4 = output disable. Priority runs in this order: `hw_rst_n` low gives reset. Otherwise `chip_en_n` high gives standby. Otherwise `wr_en_n` low with `out_en_n` high gives write. Otherwise `out_en_n` low with `wr_en_n` high gives read. Every remaining pattern, including both enables low, gives output disable.
- R2: A word-mode read (`word_mode` = 1) drives `dq_oe` = 0xFFFF and `dq_out` = the stored word. Word index i holds (i mod 256) XOR 0x5A in bits 15:8 and (i + 0x11) mod 256 in bits 7:0.
- R3: A byte-mode read (`word_mode` = 0) drives `dq_oe` = 0x00FF. Bit 15 of `dq_in` acts as address bit A-1: 0 selects bits 7:0 of the word and 1 selects bits 15:8. The selected byte appears on `dq_out[7:0]`, and `dq_out[15:8]` is 0.
- R4: In standby, output disable and write, `dq_oe` is 0 and `dq_out` is 0.
- R5: While `hw_rst_n` is low, `bus_op` is reset and nothing is driven. A write that is cut short by this reset produces no command strobe.
- R6: A word-mode write produces `cmd_addr` = {0, addr}, `cmd_data` = all 16 data bits and `cmd_byte` = 0.
- R7: A byte-mode write produces `cmd_addr` = {addr, A-1}, `cmd_data` = {8'h00, dq_in[7:0]} and `cmd_byte` = 1.
- R8: `cmd_valid` is high for exactly one cycle, two clock edges after the pins leave the write pattern. The address is taken when the write starts and the data is taken at its last sampled cycle.
- R9: Pin changes reach `bus_op`, `dq_oe` and `dq_out` on the second rising clock edge.
- R10: Writes do not change the array contents returned by reads.
- R11: The synchronous `rst` sets `bus_op` to standby and `dq_oe` and `cmd_valid` to 0.
- R12: Only the low log2(DEPTH) address bits select the word, so with DEPTH = 64 addresses that differ above bit 5 alias.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| chip_en_n | input | 1 | Chip enable, active low |
| out_en_n | input | 1 | Output enable, active low |
| wr_en_n | input | 1 | Write enable, active low |
| hw_rst_n | input | 1 | Hardware reset pin, active low |
| word_mode | input | 1 | 1 = 16-bit bus, 0 = 8-bit bus |
| addr | input | ADDR_W (17) | Word address |
| dq_in | input | DATA_W (16) | Data pins as seen by the block |
| dq_out | output | DATA_W (16) | Data pin drive values |
| dq_oe | output | DATA_W (16) | Per-pin drive enable |
| bus_op | output | 3 | Decoded bus operation |
| cmd_valid | output | 1 | One-cycle command strobe |
| cmd_addr | output | ADDR_W+1 (18) | Captured byte-granular address |
| cmd_data | output | DATA_W (16) | Captured write data |
| cmd_byte | output | 1 | Captured command came from byte mode |

## Verification
The assertions assume that the pins change only between clock edges. They also assume that each pin pattern is held for at least one full sampling cycle, because a glitch narrower than a clock period is not modelled. The stimulus changes every pin on the falling clock edge and holds each pattern for at least two rising edges. Reset is released with write enable already high, so that no unintended write cycle begins.

// File: rtl/pflash_pkg.sv
package pflash_pkg;

  typedef enum logic [2:0] {
    OP_RESET   = 3'd0,
    OP_STANDBY = 3'd1,
    OP_READ    = 3'd2,
    OP_WRITE   = 3'd3,
    OP_OUTDIS  = 3'd4
  } bus_op_e;

  function automatic bus_op_e decode_op(input logic ce_n, input logic oe_n,
                                        input logic we_n, input logic hr_n);
    if (!hr_n)             return OP_RESET;
    else if (ce_n)         return OP_STANDBY;
    else if (!we_n && oe_n) return OP_WRITE;
    else if (!oe_n && we_n) return OP_READ;
    else                   return OP_OUTDIS;
  endfunction

endpackage

// File: rtl/pflash_pin_sample.sv
module pflash_pin_sample
  import pflash_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              chip_en_n,
  input  logic              out_en_n,
  input  logic              wr_en_n,
  input  logic              hw_rst_n,
  input  logic              word_mode,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dq_in,
  output bus_op_e           s_op,
  output logic              s_word,
  output logic [ADDR_W-1:0] s_addr,
  output logic [DATA_W-1:0] s_dq
);

  logic ce_q, oe_q, we_q, hr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ce_q   <= 1'b1;
      oe_q   <= 1'b1;
      we_q   <= 1'b1;
      hr_q   <= 1'b1;
      s_word <= 1'b1;
      s_addr <= '0;
      s_dq   <= '0;
    end else begin
      ce_q   <= chip_en_n;
      oe_q   <= out_en_n;
      we_q   <= wr_en_n;
      hr_q   <= hw_rst_n;
      s_word <= word_mode;
      s_addr <= addr;
      s_dq   <= dq_in;
    end
  end

  assign s_op = decode_op(ce_q, oe_q, we_q, hr_q);

endmodule

// File: rtl/pflash_array.sv
module pflash_array #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 64,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int HALF  = DATA_W / 2
) (
  input  logic              clk,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data
);

  logic [DATA_W-1:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      mem[i] = {HALF'(i) ^ HALF'(8'h5A), HALF'(i + 8'h11)};
    end
  end

  always_ff @(posedge clk) begin
    rd_data <= mem[rd_idx];
  end

endmodule

// File: rtl/pflash_read_path.sv
module pflash_read_path
  import pflash_pkg::*;
#(
  parameter int DATA_W = 16,
  localparam int HALF  = DATA_W / 2
) (
  input  logic              clk,
  input  logic              rst,
  input  bus_op_e           s_op,
  input  logic              s_word,
  input  logic              s_lsb,
  input  logic [DATA_W-1:0] rd_data,
  output bus_op_e           op_q,
  output logic [DATA_W-1:0] dq_out,
  output logic [DATA_W-1:0] dq_oe
);

  logic word_q, lsb_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      op_q   <= OP_STANDBY;
      word_q <= 1'b1;
      lsb_q  <= 1'b0;
      dq_oe  <= '0;
    end else begin
      op_q   <= s_op;
      word_q <= s_word;
      lsb_q  <= s_lsb;
      if (s_op != OP_READ)  dq_oe <= '0;
      else if (s_word)      dq_oe <= '1;
      else                  dq_oe <= {{HALF{1'b0}}, {HALF{1'b1}}};
    end
  end

  always_comb begin
    if (op_q != OP_READ)  dq_out = '0;
    else if (word_q)      dq_out = rd_data;
    else if (lsb_q)       dq_out = {{HALF{1'b0}}, rd_data[DATA_W-1:HALF]};
    else                  dq_out = {{HALF{1'b0}}, rd_data[HALF-1:0]};
  end

endmodule

// File: rtl/pflash_cmd_latch.sv
module pflash_cmd_latch
  import pflash_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 16,
  localparam int HALF  = DATA_W / 2
) (
  input  logic              clk,
  input  logic              rst,
  input  bus_op_e           s_op,
  input  logic              s_word,
  input  logic [ADDR_W-1:0] s_addr,
  input  logic [DATA_W-1:0] s_dq,
  output logic              cmd_valid,
  output logic [ADDR_W:0]   cmd_addr,
  output logic [DATA_W-1:0] cmd_data,
  output logic              cmd_byte
);

  logic              wr_d;
  logic              byte_q;
  logic [ADDR_W:0]   addr_q;
  logic [DATA_W-1:0] data_q;
  logic              wr_now, wr_end;

  assign wr_now = (s_op == OP_WRITE);
  assign wr_end = wr_d && !wr_now && (s_op != OP_RESET);

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_d      <= 1'b0;
      byte_q    <= 1'b0;
      addr_q    <= '0;
      data_q    <= '0;
      cmd_valid <= 1'b0;
      cmd_addr  <= '0;
      cmd_data  <= '0;
      cmd_byte  <= 1'b0;
    end else begin
      wr_d      <= wr_now;
      cmd_valid <= wr_end;
      if (wr_now && !wr_d) begin
        addr_q <= s_word ? {1'b0, s_addr} : {s_addr, s_dq[DATA_W-1]};
        byte_q <= !s_word;
      end
      if (wr_now) data_q <= s_dq;
      if (wr_end) begin
        cmd_addr <= addr_q;
        cmd_data <= byte_q ? {{HALF{1'b0}}, data_q[HALF-1:0]} : data_q;
        cmd_byte <= byte_q;
      end
    end
  end

endmodule

// File: rtl/pflash_bus_if.sv
module pflash_bus_if
  import pflash_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 16,
  parameter int DEPTH  = 64,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              chip_en_n,
  input  logic              out_en_n,
  input  logic              wr_en_n,
  input  logic              hw_rst_n,
  input  logic              word_mode,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dq_in,
  output logic [DATA_W-1:0] dq_out,
  output logic [DATA_W-1:0] dq_oe,
  output logic [2:0]        bus_op,
  output logic              cmd_valid,
  output logic [ADDR_W:0]   cmd_addr,
  output logic [DATA_W-1:0] cmd_data,
  output logic              cmd_byte
);

  bus_op_e           s_op, op_q;
  logic              s_word;
  logic [ADDR_W-1:0] s_addr;
  logic [DATA_W-1:0] s_dq;
  logic [DATA_W-1:0] rd_data;

  pflash_pin_sample #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pins (
    .clk(clk), .rst(rst),
    .chip_en_n(chip_en_n), .out_en_n(out_en_n), .wr_en_n(wr_en_n),
    .hw_rst_n(hw_rst_n), .word_mode(word_mode), .addr(addr), .dq_in(dq_in),
    .s_op(s_op), .s_word(s_word), .s_addr(s_addr), .s_dq(s_dq)
  );

  pflash_array #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_array (
    .clk(clk), .rd_idx(s_addr[IDX_W-1:0]), .rd_data(rd_data)
  );

  pflash_read_path #(.DATA_W(DATA_W)) u_rd (
    .clk(clk), .rst(rst), .s_op(s_op), .s_word(s_word),
    .s_lsb(s_dq[DATA_W-1]), .rd_data(rd_data),
    .op_q(op_q), .dq_out(dq_out), .dq_oe(dq_oe)
  );

  pflash_cmd_latch #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cmd (
    .clk(clk), .rst(rst), .s_op(s_op), .s_word(s_word),
    .s_addr(s_addr), .s_dq(s_dq),
    .cmd_valid(cmd_valid), .cmd_addr(cmd_addr),
    .cmd_data(cmd_data), .cmd_byte(cmd_byte)
  );

  assign bus_op = op_q;

endmodule

// File: rtl/pflash_bus_if_chk.sv
module pflash_bus_if_chk #(
  parameter int DATA_W = 16,
  localparam int HALF  = DATA_W / 2
) (
  input logic              clk,
  input logic              rst,
  input logic [2:0]        bus_op,
  input logic [DATA_W-1:0] dq_oe,
  input logic              cmd_valid,
  input logic [DATA_W-1:0] cmd_data,
  input logic              cmd_byte
);

  localparam logic [DATA_W-1:0] LOW_LANE = {{HALF{1'b0}}, {HALF{1'b1}}};

  // R4
  drive_only_on_read_chk: assert property (@(posedge clk) disable iff (rst)
    (dq_oe != '0) |-> (bus_op == 3'd2));

  // R3
  lane_shape_chk: assert property (@(posedge clk) disable iff (rst)
    (dq_oe == '0) || (dq_oe == '1) || (dq_oe == LOW_LANE));

  // R5
  reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_op == 3'd0) |-> (dq_oe == '0));

  // R8
  strobe_single_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |=> !cmd_valid);

  // R8
  strobe_after_write_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |-> ($past(bus_op) == 3'd3));

  // R7
  byte_data_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_byte) |-> (cmd_data[DATA_W-1:HALF] == '0));

  // R11
  post_reset_idle_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!cmd_valid && dq_oe == '0 && bus_op == 3'd1));

endmodule

bind pflash_bus_if pflash_bus_if_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .bus_op(bus_op), .dq_oe(dq_oe),
  .cmd_valid(cmd_valid), .cmd_data(cmd_data), .cmd_byte(cmd_byte)
);

// File: tb/sim_pflash_bus_if.sv
`timescale 1ns/1ps
module sim_pflash_bus_if;

  logic        clk = 1'b0;
  logic        rst;
  logic        chip_en_n, out_en_n, wr_en_n, hw_rst_n, word_mode;
  logic [16:0] addr;
  logic [15:0] dq_in;
  logic [15:0] dq_out, dq_oe;
  logic [2:0]  bus_op;
  logic        cmd_valid;
  logic [17:0] cmd_addr;
  logic [15:0] cmd_data;
  logic        cmd_byte;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  pflash_bus_if u0 (
    .clk(clk), .rst(rst), .chip_en_n(chip_en_n), .out_en_n(out_en_n),
    .wr_en_n(wr_en_n), .hw_rst_n(hw_rst_n), .word_mode(word_mode),
    .addr(addr), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe),
    .bus_op(bus_op), .cmd_valid(cmd_valid), .cmd_addr(cmd_addr),
    .cmd_data(cmd_data), .cmd_byte(cmd_byte)
  );

  // {ce_n,oe_n,we_n,hw_rst_n,word_mode}, addr, A-1, exp op, exp oe, exp out
  localparam int NV = 11;
  localparam logic [57:0] VEC [NV] = '{
    {5'b00111, 17'h00003, 1'b0, 3'd2, 16'hFFFF, 16'h5914},  // R2 R9
    {5'b00111, 17'h00025, 1'b0, 3'd2, 16'hFFFF, 16'h7F36},  // R2
    {5'b00110, 17'h00003, 1'b0, 3'd2, 16'h00FF, 16'h0014},  // R3
    {5'b00110, 17'h00003, 1'b1, 3'd2, 16'h00FF, 16'h0059},  // R3
    {5'b00111, 17'h10042, 1'b0, 3'd2, 16'hFFFF, 16'h5813},  // R12
    {5'b10111, 17'h00003, 1'b0, 3'd1, 16'h0000, 16'h0000},  // R1 R4
    {5'b01111, 17'h00003, 1'b0, 3'd4, 16'h0000, 16'h0000},  // R1 R4
    {5'b00101, 17'h00003, 1'b0, 3'd0, 16'h0000, 16'h0000},  // R1 R5
    {5'b00011, 17'h00003, 1'b0, 3'd4, 16'h0000, 16'h0000},  // R1
    {5'b00110, 17'h0003F, 1'b1, 3'd2, 16'h00FF, 16'h0065},  // R3
    {5'b01011, 17'h00003, 1'b0, 3'd3, 16'h0000, 16'h0000}   // R1 R4
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle_pins();
    chip_en_n = 1'b1; out_en_n = 1'b1; wr_en_n = 1'b1;
    hw_rst_n = 1'b1; word_mode = 1'b1; addr = '0; dq_in = '0;
  endtask

  task automatic settle();
    repeat (2) @(posedge clk);
    #1;
  endtask

  task automatic do_write(input logic wmode, input logic [16:0] a, input logic [15:0] d);
    @(negedge clk);
    word_mode = wmode; addr = a; dq_in = d;
    chip_en_n = 1'b0; out_en_n = 1'b1; wr_en_n = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    wr_en_n = 1'b1; chip_en_n = 1'b1;
    settle();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    idle_pins();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    // R11 reset state
    check("R11 op", {29'd0, bus_op}, 32'd1);
    check("R11 oe", {16'd0, dq_oe}, 32'd0);
    check("R11 valid", {31'd0, cmd_valid}, 32'd0);
    @(negedge clk);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      {chip_en_n, out_en_n, wr_en_n, hw_rst_n, word_mode} = VEC[i][57:53];
      addr  = VEC[i][52:36];
      dq_in = {VEC[i][35], 15'h0000};
      settle();
      check($sformatf("R1 R2 R3 R4 R9 vec%0d op", i), {29'd0, bus_op}, {29'd0, VEC[i][34:32]});
      check($sformatf("R2 R3 R4 vec%0d oe", i), {16'd0, dq_oe}, {16'd0, VEC[i][31:16]});
      check($sformatf("R2 R3 R4 vec%0d out", i), {16'd0, dq_out}, {16'd0, VEC[i][15:0]});
    end
    @(negedge clk);
    idle_pins();
    repeat (4) @(posedge clk);

    // R6 R8 word write
    do_write(1'b1, 17'h00123, 16'hBEEF);
    check("R8 valid", {31'd0, cmd_valid}, 32'd1);
    check("R6 addr", {14'd0, cmd_addr}, 32'h00123);
    check("R6 data", {16'd0, cmd_data}, 32'hBEEF);
    check("R6 byte", {31'd0, cmd_byte}, 32'd0);
    @(posedge clk); #1;
    check("R8 single pulse", {31'd0, cmd_valid}, 32'd0);

    // R7 byte write, A-1 = 1, junk on bits 14:8
    do_write(1'b0, 17'h00456, 16'hFF3C);
    check("R7 valid", {31'd0, cmd_valid}, 32'd1);
    check("R7 addr", {14'd0, cmd_addr}, 32'h008AD);
    check("R7 data", {16'd0, cmd_data}, 32'h003C);
    check("R7 byte", {31'd0, cmd_byte}, 32'd1);

    // R10 write to word 3 leaves array unchanged
    do_write(1'b1, 17'h00003, 16'h0000);
    @(negedge clk);
    chip_en_n = 1'b0; out_en_n = 1'b0; word_mode = 1'b1; addr = 17'h00003;
    settle();
    check("R10 read after write", {16'd0, dq_out}, 32'h5914);
    @(negedge clk);
    idle_pins();

    // R5 write aborted by hardware reset
    @(negedge clk);
    addr = 17'h00077; dq_in = 16'h1234;
    chip_en_n = 1'b0; wr_en_n = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    hw_rst_n = 1'b0;
    for (int k = 0; k < 4; k++) begin
      @(posedge clk); #1;
      check("R5 no strobe on abort", {31'd0, cmd_valid}, 32'd0);
    end
    @(negedge clk);
    wr_en_n = 1'b1; chip_en_n = 1'b1;
    @(negedge clk);
    hw_rst_n = 1'b1;
    for (int k = 0; k < 3; k++) begin
      @(posedge clk); #1;
      check("R5 no strobe after release", {31'd0, cmd_valid}, 32'd0);
    end

    // R11 synchronous reset during a read
    @(negedge clk);
    chip_en_n = 1'b0; out_en_n = 1'b0; addr = 17'h00005;
    settle();
    check("R2 read idx5", {16'd0, dq_out}, 32'h5F16);
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk); #1;
    check("R11 oe cleared", {16'd0, dq_oe}, 32'd0);
    check("R11 op standby", {29'd0, bus_op}, 32'd1);
    @(negedge clk);
    idle_pins();
    rst = 1'b0;
    repeat (2) @(posedge clk);
    finish_run();
  end

endmodule